// File: doc/BRIEF.md
# Sign-Magnitude Adder-Subtractor

This unit adds or subtracts two numbers held in sign-magnitude form. Each operand is five bits wide. The top bit is the sign and the four bits below it are an unsigned magnitude. One 4-bit ripple adder does all the arithmetic. An XOR stage in front of its second input inverts that input for a magnitude subtraction, and the same control drives the carry into bit 0. The adder is used twice in one operation: once for the main magnitude pass, and once more to form the two's complement when the difference came out negative.

A start strobe latches the operands and the operation. The magnitude pass runs on the next clock and captures the end carry. A correction pass runs on the clock after that, and a one-cycle done pulse then marks the registered sign, magnitude, end-carry flag and overflow flag as valid. These results stay unchanged until the next accepted start.

Top module: `sm_addsub`

## Requirements
- R1: A synchronous active-high reset clears the result sign, result magnitude, end-carry flag, overflow flag and done to 0.
- R2: Operand bit 4 is the sign (1 = negative) and bits 3..0 are the magnitude. An opSel of 0 selects add and 1 selects subtract. The final result equals the signed value of opA plus or minus opB, reduced to a 4-bit magnitude.
- R3: When magnitudes are added (add with equal signs, or subtract with unequal signs), the result magnitude is (|A|+|B|) mod 16. The end carry is bit 4 of that sum, the overflow flag equals the end carry, and the result sign is the sign of opA.
- R4: When magnitudes are subtracted (add with unequal signs, or subtract with equal signs) and |A| >= |B|, the result magnitude is |A|-|B|, the end carry is 1, the overflow flag is 0, and the sign is the sign of opA.
- R5: A magnitude subtraction whose difference is zero always gives a positive result (sign 0).
- R6: When magnitudes are subtracted and |A| < |B|, the end carry is 0, the overflow flag is 0, the result magnitude is |B|-|A| (the two's complement of the raw difference), and the sign is the inverse of the sign of opA.
- R7: If start is sampled high at clock edge k while the unit is idle, done is high for exactly the one cycle that follows edge k+2. Done is low in the cycles after edges k and k+1 and after edge k+3.
- R8: A start that arrives during the two cycles of an operation is ignored: it changes neither the result nor the timing of done.
- R9: While no start is accepted, the result sign, magnitude, end carry and overflow flag hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation (taken only when idle) |
| opSel | input | 1 | 0 = add, 1 = subtract |
| opA | input | 5 | First operand, sign in bit 4 |
| opB | input | 5 | Second operand, sign in bit 4 |
| resSign | output | 1 | Result sign |
| resMag | output | 4 | Result magnitude |
| endCarry | output | 1 | Carry out of the magnitude pass |
| ovf | output | 1 | Overflow flag |
| done | output | 1 | One-cycle pulse when the result is valid |

## Verification
The assertions assume that reset is applied before the first operation. They also assume that the operands and opSel hold their values at the edge where start is sampled; they need not be stable after that, because the unit latches them there. The hold and no-negative-zero properties rest on the result registers being written only inside an accepted operation. The bench therefore changes inputs only on falling edges. It raises start for a single cycle except in the busy-overlap scenario, where it deliberately holds start high and changes the operands while an operation is in flight.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADD  = 2'd1,
    ST_FIX  = 2'd2
  } seqState_t;

  typedef struct packed {
    logic load;
    logic addStep;
    logic fixStep;
  } ctlStrobes_t;
endpackage

// File: rtl/sm_ripple_adder.sv
module sm_ripple_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic         subCtl,
  output logic [W-1:0] sumOut,
  output logic         carryOut
);
  logic [W:0]   carry;
  logic [W-1:0] bX;

  assign carry[0] = subCtl;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bX[i]      = bIn[i] ^ subCtl;
    assign sumOut[i]  = aIn[i] ^ bX[i] ^ carry[i];
    assign carry[i+1] = (aIn[i] & bX[i]) | (aIn[i] & carry[i]) | (bX[i] & carry[i]);
  end

  assign carryOut = carry[W];
endmodule

// File: rtl/sm_control.sv
module sm_control
  import sm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  output ctlStrobes_t ctl,
  output logic        busy,
  output logic        done
);
  seqState_t state;

  always_comb begin
    ctl         = '0;
    ctl.load    = (state == ST_IDLE) && start;
    ctl.addStep = (state == ST_ADD);
    ctl.fixStep = (state == ST_FIX);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) state <= ST_ADD;
        ST_ADD:  state <= ST_FIX;
        ST_FIX: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: done lasts a single cycle
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: once begun, the sequence advances regardless of start
  p_add_to_fix_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ADD) |=> (state == ST_FIX));
  p_fix_to_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIX) |=> (state == ST_IDLE) && done);
endmodule

// File: rtl/sm_datapath.sv
module sm_datapath
  import sm_pkg::*;
#(
  parameter int MAG_W = 4,
  localparam int OP_W = MAG_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobes_t      ctl,
  input  logic             opSel,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  output logic             accSign,
  output logic [MAG_W-1:0] accMag,
  output logic             eFlag,
  output logic             avfFlag
);
  logic [OP_W-1:0]  regA, regB;
  logic             regOp;
  logic             subDone;

  logic             aSign, bSign, magSub;
  logic [MAG_W-1:0] addA, addB, addSum;
  logic             addSub, addCarry;

  assign aSign  = regA[OP_W-1];
  assign bSign  = regB[OP_W-1];
  assign magSub = regOp ^ aSign ^ bSign;

  // shared adder: magnitude pass, then complement pass (0 + ~acc + 1)
  always_comb begin
    if (ctl.fixStep) begin
      addA   = '0;
      addB   = accMag;
      addSub = 1'b1;
    end else begin
      addA   = regA[MAG_W-1:0];
      addB   = regB[MAG_W-1:0];
      addSub = magSub;
    end
  end

  sm_ripple_adder #(.W(MAG_W)) u_adder (
    .aIn     (addA),
    .bIn     (addB),
    .subCtl  (addSub),
    .sumOut  (addSum),
    .carryOut(addCarry)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      regA    <= '0;
      regB    <= '0;
      regOp   <= 1'b0;
      subDone <= 1'b0;
      accSign <= 1'b0;
      accMag  <= '0;
      eFlag   <= 1'b0;
      avfFlag <= 1'b0;
    end else if (ctl.load) begin
      regA  <= opA;
      regB  <= opB;
      regOp <= opSel;
    end else if (ctl.addStep) begin
      accMag  <= addSum;
      accSign <= aSign;
      eFlag   <= addCarry;
      avfFlag <= magSub ? 1'b0 : addCarry;
      subDone <= magSub;
    end else if (ctl.fixStep && subDone) begin
      if (!eFlag) begin
        accMag  <= addSum;
        accSign <= ~accSign;
      end else if (accMag == '0) begin
        accSign <= 1'b0;
      end
    end
  end

  // R5: a magnitude subtraction never leaves negative zero
  p_no_neg_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (ctl.fixStep && subDone) |=> !(accSign && (accMag == '0)));

  // R4: overflow flag is clear after a magnitude subtraction
  p_avf_clear_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl.addStep && magSub) |=> !avfFlag);

  // R6: the complement pass keeps the end carry at zero
  p_carry_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (ctl.fixStep && subDone && !eFlag) |=> !eFlag);
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
  import sm_pkg::*;
#(
  parameter int MAG_W = 4,
  localparam int OP_W = MAG_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             opSel,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  output logic             resSign,
  output logic [MAG_W-1:0] resMag,
  output logic             endCarry,
  output logic             ovf,
  output logic             done
);
  ctlStrobes_t ctl;
  logic        busy;

  sm_control u_ctl (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .ctl  (ctl),
    .busy (busy),
    .done (done)
  );

  sm_datapath #(.MAG_W(MAG_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .opSel  (opSel),
    .opA    (opA),
    .opB    (opB),
    .accSign(resSign),
    .accMag (resMag),
    .eFlag  (endCarry),
    .avfFlag(ovf)
  );

  // R9: results hold while idle and no start arrives
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(resSign) && $stable(resMag)
                           && $stable(endCarry) && $stable(ovf)));

  // R1: reset leaves everything cleared
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!done && !resSign && resMag == '0 && !endCarry && !ovf));
endmodule

// File: tb/sm_addsub_test.sv
module sm_addsub_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       opSel = 1'b0;
  logic [4:0] opA = '0;
  logic [4:0] opB = '0;
  logic       resSign;
  logic [3:0] resMag;
  logic       endCarry;
  logic       ovf;
  logic       done;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sm_addsub uut (
    .clk(clk), .rst(rst), .start(start), .opSel(opSel),
    .opA(opA), .opB(opB), .resSign(resSign), .resMag(resMag),
    .endCarry(endCarry), .ovf(ovf), .done(done)
  );

  // packed {sign, mag[3:0], e, avf}
  function automatic logic [6:0] expect_res(input logic [4:0] a, input logic [4:0] b,
                                            input logic sub);
    logic sa, sb, effSub, sg, e, v;
    logic [3:0] ma, mb, m;
    logic [4:0] s;
    sa = a[4]; sb = b[4]; ma = a[3:0]; mb = b[3:0];
    effSub = sub ? (sa == sb) : (sa != sb);
    if (!effSub) begin
      s = {1'b0, ma} + {1'b0, mb};
      m = s[3:0]; e = s[4]; v = s[4]; sg = sa;
    end else if (ma >= mb) begin
      m = ma - mb; e = 1'b1; v = 1'b0; sg = (m == 4'd0) ? 1'b0 : sa;
    end else begin
      m = mb - ma; e = 1'b0; v = 1'b0; sg = ~sa;
    end
    return {sg, m, e, v};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [6:0] act,
                       input logic [6:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] outs();
    return {resSign, resMag, endCarry, ovf};
  endfunction

  // run one operation with full timing checks (R7)
  task automatic run_op(input logic [4:0] a, input logic [4:0] b, input logic sub,
                        input string tag);
    logic [6:0] exp;
    exp = expect_res(a, b, sub);
    @(negedge clk); opA = a; opB = b; opSel = sub; start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!done, "R7 done early k", {6'd0, done}, 7'd0);
    @(negedge clk);
    check(!done, "R7 done early k+1", {6'd0, done}, 7'd0);
    @(negedge clk);
    check(done, "R7 done at k+2", {6'd0, done}, 7'd1);
    check(outs() == exp, tag, outs(), exp);
    @(negedge clk);
    check(!done, "R7 done width", {6'd0, done}, 7'd0);
  endtask

  task automatic t_reset();
    check(outs() == 7'd0 && !done, "R1 reset state", outs(), 7'd0);
  endtask

  task automatic t_directed();
    run_op(5'b0_0011, 5'b0_0100, 1'b0, "R3 3+4");
    run_op(5'b0_1001, 5'b0_1000, 1'b0, "R3 9+8 overflow");
    run_op(5'b1_0101, 5'b1_0010, 1'b0, "R3 -5+-2");
    run_op(5'b0_0101, 5'b1_0011, 1'b1, "R3 5-(-3)");
    run_op(5'b0_1100, 5'b0_0101, 1'b1, "R4 12-5");
    run_op(5'b1_0111, 5'b0_0010, 1'b0, "R4 -7+2");
    run_op(5'b1_0101, 5'b1_0101, 1'b1, "R5 -5-(-5)");
    run_op(5'b1_0110, 5'b0_0110, 1'b0, "R5 -6+6");
    run_op(5'b0_0010, 5'b0_0111, 1'b1, "R6 2-7");
    run_op(5'b0_0011, 5'b1_0111, 1'b0, "R6 3+(-7)");
    run_op(5'b1_0000, 5'b1_1111, 1'b1, "R6 -0-(-15)");
  endtask

  task automatic t_sweep();
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++)
        for (int s = 0; s < 2; s++)
          run_op(a[4:0], b[4:0], s[0], "R2 sweep");
  endtask

  task automatic t_busy_ignore();
    logic [6:0] exp;
    exp = expect_res(5'b0_0110, 5'b0_0001, 1'b0);
    @(negedge clk); opA = 5'b0_0110; opB = 5'b0_0001; opSel = 1'b0; start = 1'b1;
    @(negedge clk); opA = 5'b1_1111; opB = 5'b0_1111; opSel = 1'b1;
    check(!done, "R8 no early done", {6'd0, done}, 7'd0);
    @(negedge clk); opA = 5'b0_1010; opB = 5'b1_0011;
    check(!done, "R8 no early done", {6'd0, done}, 7'd0);
    @(negedge clk); start = 1'b0;
    check(done, "R8 done on time", {6'd0, done}, 7'd1);
    check(outs() == exp, "R8 busy starts ignored", outs(), exp);
    @(negedge clk);
    check(!done, "R8 single done", {6'd0, done}, 7'd0);
  endtask

  task automatic t_hold();
    logic [6:0] held;
    run_op(5'b1_0010, 5'b0_1001, 1'b1, "R9 setup");
    held = outs();
    opA = 5'b0_0001; opB = 5'b0_0001; opSel = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check(outs() == held && !done, "R9 hold", outs(), held);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_directed();
    t_busy_ignore();
    t_hold();
    t_sweep();
    // reset mid-result clears everything
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    t_reset();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule